// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers every interrupt cause of a serial bus link controller into one top-level status byte and drives one CPU interrupt line from it. Four of the top bits latch single-cycle event pulses: the end of the self-ID phase, a self-ID fault, an error from the protocol offload engine, and a bus reset that arrives while that engine is working. The other four bits summarise four second-level banks: DMA, PHY and two link-core banks. Each bank is an 8-bit status register that event pulses set and that a write of ones clears, paired with an 8-bit enable mask.

A byte-wide register bus reaches every register. Reads return data one cycle after the request and change no state. The CPU reads the top status byte, handles the banks it points to, and then writes back the value it read. A 1 clears a latched event bit. A summary bit ignores the write and falls only after every enabled cause in its bank has been cleared or masked. A top-level enable byte picks which status bits may raise the interrupt line.

Top module: `irq_aggregator`

## Requirements
- R1: After a cycle with `rst_n` low, every status register, every enable register, `irq` and `rd_valid` are 0.
- R2: A pulse sets a top status bit in the clock edge where it is sampled, and the bit stays set until it is cleared. The pulses map to bits as follows: `selfid_done_pulse` to bit 7, `selfid_err_pulse` to bit 6, `offload_err_pulse` to bit 5 and `offload_busrst_pulse` to bit 4.
- R3: A write to the top status address 0x01 clears each of bits 7..4 whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: When a pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: In bank k, an event input bit sets the matching status bit. A write of ones to the bank status address clears those bits, and set wins when both happen in the same cycle.
- R6: One cycle after a change, top bit k equals the OR over bank k of status AND enable. Bank 0 is DMA, bank 1 is PHY, bank 2 is link core 0 and bank 3 is link core 1.
- R7: A write to 0x01 does not clear bits 3..0. Such a bit falls only when no enabled cause remains in its bank.
- R8: `irq` is a register. It is 1 in the cycle after (top status AND top enable) is nonzero, and 0 in the cycle after it is zero.
- R9: A read request sets `rd_valid` in the next cycle, with `rd_data` holding the register value from before that edge. Reads change no state, and an unmapped address reads 0.
- R10: The address map is: top status at 0x01, top enable at 0x02 (read/write), bank k status at 0x10+2k and bank k enable at 0x11+2k (read/write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the request) |
| rd_data | output | 8 | Read data |
| selfid_done_pulse | input | 1 | Self-ID phase finished |
| selfid_err_pulse | input | 1 | Self-ID packet or phase error |
| offload_err_pulse | input | 1 | Offload engine error factor |
| offload_busrst_pulse | input | 1 | Bus reset during offload processing |
| dma_events | input | 8 | Bank 0 event pulses |
| phy_events | input | 8 | Bank 1 event pulses |
| link0_events | input | 8 | Bank 2 event pulses |
| link1_events | input | 8 | Bank 3 event pulses |
| irq | output | 1 | CPU interrupt request |

## Verification
Internal state can only be seen through readback and the interrupt line, so a bad latched bit or a bad mask shows up at the first read of the affected register, one cycle after the request. It also shows up on `irq` one cycle after the top status changes, or two cycles after a bank changes. A summary bit that clears when it should not, or that stays set too long, makes the next read of 0x01 differ from the reference. Enabling that bit also gives `irq` the wrong level within two cycles. A lost race between a pulse and a clearing write shows up as a missing bit on the following read.

// File: rtl/irq_agg_pkg.sv
// Shared constants for the interrupt aggregator: data and address widths,
// number of banks, the bit position of each latched event, and the address map.
package irq_agg_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int NUM_BANKS  = 4;
    localparam int NUM_STICKY = 4;
    localparam int STICKY_LSB = DATA_W - NUM_STICKY;

    localparam logic [ADDR_W-1:0] ADDR_TOP_STAT  = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_TOP_EN    = 8'h02;
    localparam logic [ADDR_W-1:0] ADDR_BANK_BASE = 8'h10;

    // Address of the status register of bank k
    function automatic logic [ADDR_W-1:0] bank_stat_addr(input int k);
        return ADDR_BANK_BASE + ADDR_W'(2 * k);
    endfunction

    // Address of the enable register of bank k
    function automatic logic [ADDR_W-1:0] bank_en_addr(input int k);
        return ADDR_BANK_BASE + ADDR_W'(2 * k + 1);
    endfunction
endpackage

// File: rtl/irq_sub_bank.sv
// Second-level cause bank: a status register with write-one-to-clear and an
// enable mask. The pending output is the OR of the enabled status bits.
// Assumes event pulses last one cycle. When a pulse and a clear hit the same
// bit in the same cycle, the bit stays set.
module irq_sub_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] en_q,
    output logic         pending
);
    logic [W-1:0] clr_mask;

    // Clear mask applies only on a status write
    always_comb clr_mask = clr_we ? wdata : '0;

    // Status bits: clear then set, so the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | evt;
    end

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wdata;
    end

    // Bank summary for the top level
    always_comb pending = |(stat_q & en_q);
endmodule

// File: rtl/irq_top_status.sv
// Top-level status byte. The upper bits latch event pulses and are cleared by
// writing ones to them. The lower bits copy the bank summaries every cycle,
// so a clearing write cannot remove them while a cause is still pending.
module irq_top_status
    import irq_agg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STICKY-1:0] sticky_set,
    input  logic                  clr_we,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_BANKS-1:0]  summary,
    output logic [DATA_W-1:0]     stat_q
);
    logic [NUM_STICKY-1:0] sticky_clr;

    // Only the latched event bits respond to a clearing write
    always_comb sticky_clr = clr_we ? wdata[DATA_W-1:STICKY_LSB] : '0;

    // Latched event bits, where the set wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q[DATA_W-1:STICKY_LSB] <= '0;
        else        stat_q[DATA_W-1:STICKY_LSB] <=
                        (stat_q[DATA_W-1:STICKY_LSB] & ~sticky_clr) | sticky_set;
    end

    // Summary bits, resampled from the banks every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q[NUM_BANKS-1:0] <= '0;
        else        stat_q[NUM_BANKS-1:0] <= summary;
    end
endmodule

// File: rtl/irq_reg_bus.sv
// Register bus front end: decodes writes into per-register strobes and
// returns read data one cycle after the request. Reads have no side effects
// and an unmapped address reads 0. Assumes one request per cycle at most.
module irq_reg_bus
    import irq_agg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           top_stat,
    input  logic [DATA_W-1:0]           top_en,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_stat,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_en,
    output logic                        top_clr_we,
    output logic                        top_en_we,
    output logic [NUM_BANKS-1:0]        bank_clr_we,
    output logic [NUM_BANKS-1:0]        bank_en_we,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data
);
    logic              wr_req;
    logic              rd_req;
    logic [DATA_W-1:0] rd_mux;

    // Split the request into read and write
    always_comb begin
        wr_req = req_valid && req_write;
        rd_req = req_valid && !req_write;
    end

    // Top-level write strobes
    always_comb begin
        top_clr_we = wr_req && (req_addr == ADDR_TOP_STAT);
        top_en_we  = wr_req && (req_addr == ADDR_TOP_EN);
    end

    // One pair of write strobes per bank
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank_dec
        assign bank_clr_we[k] = wr_req && (req_addr == bank_stat_addr(k));
        assign bank_en_we[k]  = wr_req && (req_addr == bank_en_addr(k));
    end

    // Read data select
    always_comb begin
        rd_mux = '0;
        if (req_addr == ADDR_TOP_STAT) rd_mux = top_stat;
        if (req_addr == ADDR_TOP_EN)   rd_mux = top_en;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (req_addr == bank_stat_addr(k)) rd_mux = bank_stat[k*DATA_W +: DATA_W];
            if (req_addr == bank_en_addr(k))   rd_mux = bank_en[k*DATA_W +: DATA_W];
        end
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
// Top of the two-level interrupt aggregator. It joins four second-level banks
// (0 DMA, 1 PHY, 2 link core 0, 3 link core 1), the top status byte, the top
// enable byte and the registered interrupt line. Assumes a single clock and
// event pulses that last one cycle.
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              selfid_done_pulse,
    input  logic              selfid_err_pulse,
    input  logic              offload_err_pulse,
    input  logic              offload_busrst_pulse,
    input  logic [DATA_W-1:0] dma_events,
    input  logic [DATA_W-1:0] phy_events,
    input  logic [DATA_W-1:0] link0_events,
    input  logic [DATA_W-1:0] link1_events,
    output logic              irq
);
    logic [NUM_BANKS*DATA_W-1:0] bank_evt;
    logic [NUM_BANKS*DATA_W-1:0] bank_stat;
    logic [NUM_BANKS*DATA_W-1:0] bank_en;
    logic [NUM_BANKS-1:0]        bank_pending;
    logic [NUM_BANKS-1:0]        bank_clr_we;
    logic [NUM_BANKS-1:0]        bank_en_we;
    logic [NUM_STICKY-1:0]       sticky_set;
    logic [DATA_W-1:0]           top_stat_q;
    logic [DATA_W-1:0]           top_en_q;
    logic                        top_clr_we;
    logic                        top_en_we;

    // Gather the bank event inputs in bank order
    always_comb bank_evt = {link1_events, link0_events, phy_events, dma_events};

    // Gather the latched event pulses in bit order (MSB first)
    always_comb sticky_set = {selfid_done_pulse, selfid_err_pulse,
                              offload_err_pulse, offload_busrst_pulse};

    irq_reg_bus u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .top_stat   (top_stat_q),
        .top_en     (top_en_q),
        .bank_stat  (bank_stat),
        .bank_en    (bank_en),
        .top_clr_we (top_clr_we),
        .top_en_we  (top_en_we),
        .bank_clr_we(bank_clr_we),
        .bank_en_we (bank_en_we),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        irq_sub_bank #(.W(DATA_W)) u_sub (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (bank_evt[k*DATA_W +: DATA_W]),
            .clr_we (bank_clr_we[k]),
            .en_we  (bank_en_we[k]),
            .wdata  (req_wdata),
            .stat_q (bank_stat[k*DATA_W +: DATA_W]),
            .en_q   (bank_en[k*DATA_W +: DATA_W]),
            .pending(bank_pending[k])
        );
    end

    irq_top_status u_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .sticky_set(sticky_set),
        .clr_we    (top_clr_we),
        .wdata     (req_wdata),
        .summary   (bank_pending),
        .stat_q    (top_stat_q)
    );

    // Top-level enable register
    always_ff @(posedge clk) begin
        if (!rst_n)         top_en_q <= '0;
        else if (top_en_we) top_en_q <= req_wdata;
    end

    // Registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(top_stat_q & top_en_q);
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
// Assertion checker for irq_aggregator, bound to every instance of it.
// It watches the ports and the state between the submodules.
module irq_aggregator_chk
    import irq_agg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [DATA_W-1:0]     req_wdata,
    input logic [NUM_STICKY-1:0] sticky_ev,
    input logic [DATA_W-1:0]     top_stat,
    input logic [DATA_W-1:0]     top_en,
    input logic [NUM_BANKS-1:0]  bank_pend,
    input logic                  rd_valid,
    input logic                  irq
);
    logic                  stat_clr_wr;
    logic [NUM_STICKY-1:0] sticky_keep;

    // Latched bits that no write is clearing in this cycle
    always_comb begin
        stat_clr_wr = req_valid && req_write && (req_addr == ADDR_TOP_STAT);
        sticky_keep = top_stat[DATA_W-1:STICKY_LSB] &
                      ~(stat_clr_wr ? req_wdata[DATA_W-1:STICKY_LSB] : '0);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (top_stat == '0 && top_en == '0 && !irq && !rd_valid));

    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((top_stat[DATA_W-1:STICKY_LSB] & $past(sticky_keep)) == $past(sticky_keep)));

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && |sticky_ev) |=>
        ((top_stat[DATA_W-1:STICKY_LSB] & $past(sticky_ev)) == $past(sticky_ev)));

    a_r6_summary_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (top_stat[NUM_BANKS-1:0] == $past(bank_pend)));

    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && |(top_stat & top_en)) |=> irq);

    a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(|(top_stat & top_en))) |=> !irq);

    a_r9_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rd_valid == $past(req_valid && !req_write)));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .sticky_ev(sticky_set),
    .top_stat (top_stat_q),
    .top_en   (top_en_q),
    .bank_pend(bank_pending),
    .rd_valid (rd_valid),
    .irq      (irq)
);

// File: tb/irq_aggregator_bench.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared each cycle against a reference model kept in the bench.
module irq_aggregator_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic [3:0] ev_sticky = 4'h0;   // {done, err, offload err, offload busrst}
    logic [7:0] b_ev [4];
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model state
    logic [7:0] m_top, m_ten, m_rd, m_rd_addr;
    logic [7:0] m_bs [4];
    logic [7:0] m_be [4];
    logic       m_irq, m_rdv;

    always #4 clk = ~clk;   // 125 MHz

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .selfid_done_pulse(ev_sticky[3]), .selfid_err_pulse(ev_sticky[2]),
        .offload_err_pulse(ev_sticky[1]), .offload_busrst_pulse(ev_sticky[0]),
        .dma_events(b_ev[0]), .phy_events(b_ev[1]),
        .link0_events(b_ev[2]), .link1_events(b_ev[3]),
        .irq(irq)
    );

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == 8'h01) return m_top;
        if (a == 8'h02) return m_ten;
        if (a >= 8'h10 && a < 8'h18) begin
            int idx = int'((a - 8'h10) >> 1);
            return a[0] ? m_be[idx] : m_bs[idx];
        end
        return 8'h00;
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        if (a == 8'h01) return "R3";
        if (a == 8'h02) return "R10";
        if (a >= 8'h10 && a < 8'h18) return a[0] ? "R10" : "R5";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance the model by one edge, using the inputs applied before it
    task automatic model_step();
        logic [7:0] nt, nten;
        logic [7:0] nbs [4];
        logic [7:0] nbe [4];
        logic [3:0] clr;
        bit wr, rd;
        if (!rst_n) begin
            m_top = 0; m_ten = 0; m_irq = 0; m_rdv = 0; m_rd = 0;
            for (int k = 0; k < 4; k++) begin m_bs[k] = 0; m_be[k] = 0; end
            return;
        end
        wr = req_valid && req_write;
        rd = req_valid && !req_write;
        clr = (wr && req_addr == 8'h01) ? req_wdata[7:4] : 4'h0;
        nt[7:4] = (m_top[7:4] & ~clr) | ev_sticky;
        for (int k = 0; k < 4; k++) nt[k] = |(m_bs[k] & m_be[k]);
        nten = (wr && req_addr == 8'h02) ? req_wdata : m_ten;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] sa, ea;
            sa = 8'h10 + 8'(2 * k);
            ea = sa + 8'h01;
            nbs[k] = (m_bs[k] & ~((wr && req_addr == sa) ? req_wdata : 8'h00)) | b_ev[k];
            nbe[k] = (wr && req_addr == ea) ? req_wdata : m_be[k];
        end
        if (rd) begin m_rd = m_read(req_addr); m_rd_addr = req_addr; end
        m_rdv = rd;
        m_irq = |(m_top & m_ten);
        m_top = nt; m_ten = nten;
        for (int k = 0; k < 4; k++) begin m_bs[k] = nbs[k]; m_be[k] = nbe[k]; end
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R8", {7'd0, irq}, {7'd0, m_irq});
        check("R9", {7'd0, rd_valid}, {7'd0, m_rdv});
        if (m_rdv) check(tag_for(m_rd_addr), rd_data, m_rd);
    endtask

    task automatic idle();
        req_valid = 0; req_write = 0; ev_sticky = 0;
        for (int k = 0; k < 4; k++) b_ev[k] = 8'h00;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        tick();
        idle();
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        req_valid = 1; req_write = 0; req_addr = a;
        tick();
        check(tag, rd_data, exp);
        idle();
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        // R1: reset state at the ports and in readback
        check("R1", {7'd0, irq}, 8'h00);
        expect_read(8'h01, 8'h00, "R1");
        expect_read(8'h02, 8'h00, "R1");
        expect_read(8'h14, 8'h00, "R1");
        expect_read(8'h15, 8'h00, "R1");
        expect_read(8'h3F, 8'h00, "R9");
        // R2: self-ID done latches bit 7
        ev_sticky = 4'b1000; tick(); idle(); tick();
        expect_read(8'h01, 8'h80, "R2");
        expect_read(8'h01, 8'h80, "R9");
        // R3: writing zeros keeps the bit, writing a one clears it
        bus_write(8'h01, 8'h00);
        expect_read(8'h01, 8'h80, "R3");
        bus_write(8'h01, 8'h80);
        expect_read(8'h01, 8'h00, "R3");
        ev_sticky = 4'b0011; tick(); idle();
        expect_read(8'h01, 8'h30, "R2");
        bus_write(8'h01, 8'h10);
        expect_read(8'h01, 8'h20, "R3");
        bus_write(8'h01, 8'h20);
        // R4: a pulse and a clear in the same cycle leave the bit set
        ev_sticky = 4'b0100;
        bus_write(8'h01, 8'h40);
        expect_read(8'h01, 8'h40, "R4");
        // R5/R6: link core 0 bank drives top bit 2
        bus_write(8'h15, 8'hFF);
        b_ev[2] = 8'h08; tick(); idle(); tick();
        expect_read(8'h14, 8'h08, "R5");
        expect_read(8'h01, 8'h44, "R6");
        // R7: writing a one to a summary bit does not clear it
        bus_write(8'h01, 8'h04);
        tick();
        expect_read(8'h01, 8'h44, "R7");
        bus_write(8'h14, 8'h08);
        tick();
        expect_read(8'h01, 8'h40, "R7");
        // R7: masking the remaining cause also drops the summary
        b_ev[0] = 8'h01; bus_write(8'h11, 8'h01); tick();
        expect_read(8'h01, 8'h41, "R6");
        bus_write(8'h11, 8'h00); tick();
        expect_read(8'h01, 8'h40, "R7");
        bus_write(8'h10, 8'hFF);
        // R8: registered interrupt rises and falls one cycle late
        bus_write(8'h02, 8'h40);
        check("R8", {7'd0, irq}, 8'h00);
        tick();
        check("R8", {7'd0, irq}, 8'h01);
        bus_write(8'h01, 8'h40);
        check("R8", {7'd0, irq}, 8'h01);
        tick();
        check("R8", {7'd0, irq}, 8'h00);

        // Random traffic, with one reset in the middle
        for (int i = 0; i < 3000; i++) begin
            int sel, op;
            if (i == 1500) begin
                rst_n = 0; tick(); rst_n = 1;
                expect_read(8'h02, 8'h00, "R1");
            end
            sel = int'($urandom % 12);
            op  = int'($urandom % 10);
            req_addr = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h01 : (sel == 2) ? 8'h02 :
                       (sel == 11) ? 8'h3F : 8'h10 + 8'(sel - 3);
            req_wdata = 8'($urandom);
            req_valid = (op < 8);
            req_write = (op >= 5);
            for (int b = 0; b < 4; b++)
                ev_sticky[b] = (($urandom % 16) == 0);
            for (int k = 0; k < 4; k++)
                b_ev[k] = 8'($urandom & $urandom & $urandom & $urandom);
            tick();
        end
        idle();
        tick();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule